// File: doc/BRIEF.md
# Bus Transmit Path Guard

This block watches over the transmit side of a single-wire bus transceiver. It takes the local transmit data and the level seen on the bus, and produces one transmit-enable output that gates the line driver. Two independent checks can switch the driver off. A bit-compare check fires when the bus fails to follow the transmit data for too long. A stuck-low watchdog fires when the transmit data has been low for too many cycles. After either trip, the driver comes back only once both the transmit data and the bus have been high without a break for a qualification window.

A three-state control pin is modelled as three signals. While an external source drives it, its level overrides both checks: low forces the driver on and high forces it off. While nobody drives it, the block drives it as a status output, high meaning the driver is off. Both checks keep running under an override, so the internal state is already current when the override is released. All times are parameters counted in clock cycles. Both inputs pass through synchronizers, and the synchronized bus level is also given out as the receive output, which keeps working while transmission is blocked.

Top module: `tx_path_guard`

## Requirements
- R1: `rxd_o` equals `bus_in` delayed by two clock edges, whatever the transmit-enable state. Both inputs are seen only after this two-stage synchronization, so all sample counts below are in synchronized samples.
- R2: During reset and after it, the internal enable is off. `tx_en_o` is 0 and, with no override present, `status_o` is 1.
- R3: While enabled, a run of T_BC+1 consecutive samples in which transmit data and bus differ turns the internal enable off at the next edge. A run of T_BC or fewer has no effect on `tx_en_o`.
- R4: While disabled, the internal enable turns on after T_ENA consecutive samples with both transmit data and bus high. Any sample without both high restarts the count.
- R5: While enabled, the T_LOW-th accumulated low sample of transmit data turns the internal enable off at the next edge.
- R6: A high run of at least T_REC samples on transmit data clears the accumulated low count. A shorter high run leaves the count unchanged, so low runs on either side of it add up.
- R7: With `ovr_valid_i`=1 and `ovr_value_i`=0, `tx_en_o` is 1 regardless of both checks.
- R8: With `ovr_valid_i`=1 and `ovr_value_i`=1, `tx_en_o` is 0 regardless of the internal state.
- R9: `status_oe_o` equals the inverse of `ovr_valid_i`. While it is 1, `status_o` is 1 when transmit is disabled and 0 when enabled.
- R10: Both checks and the qualification keep running during an override. On release, `tx_en_o` shows the internal state reached meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_in | input | 1 | Local transmit data, asynchronous |
| bus_in | input | 1 | Received bus level, asynchronous |
| ovr_valid_i | input | 1 | Control pin is being driven externally |
| ovr_value_i | input | 1 | Level driven on the control pin (0 force on, 1 force off) |
| rxd_o | output | 1 | Synchronized bus level for the receiver |
| tx_en_o | output | 1 | Transmit driver enable |
| status_o | output | 1 | Status level for the control pin (1 = disabled) |
| status_oe_o | output | 1 | Drive enable for the status level |

## Verification
The hardest state to reach is a stuck-low trip built from several low runs separated by high pulses one cycle too short to clear the count. In that situation the low samples add up across the pulses. The stimulus keeps the bus looped back to the transmit data so the bit-compare check stays quiet. It then lays out low runs of 20 and 15 cycles around a 2-cycle high pulse, and repeats the same pattern with a 3-cycle pulse that must clear the count. It also leaves an override in place across an internal trip and requalification, and after that runs a long randomized stretch with sticky data runs, rare mismatches and occasional overrides.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic {
        TX_OFF = 1'b0,
        TX_ON  = 1'b1
    } tx_state_e;

    // Counter width able to hold values 0..maxv
    function automatic int unsigned cnt_w(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/tpg_sync.sv
module tpg_sync #(
    parameter int unsigned     W       = 2,
    parameter int unsigned     STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg_d;
    logic [STAGES-1:0][W-1:0] stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/tpg_bitcmp.sv
module tpg_bitcmp #(
    parameter int unsigned T_BC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_s,
    input  logic bus_s,
    output logic bc_fault
);

    localparam int unsigned CW = tpg_pkg::cnt_w(T_BC);

    typedef struct packed {
        logic [CW-1:0] mis;
    } bc_st_t;

    bc_st_t st_d, st_q;
    logic   differ;

    always_comb begin
        st_d     = st_q;
        differ   = txd_s ^ bus_s;
        bc_fault = differ && (st_q.mis >= CW'(T_BC));
        if (differ) begin
            if (st_q.mis < CW'(T_BC)) begin
                st_d.mis = st_q.mis + 1'b1;
            end
        end else begin
            st_d.mis = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a trip needs a mismatch in the previous sample as well
    assert_bc_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bc_fault |-> $past(txd_s ^ bus_s));

endmodule

// File: rtl/tpg_lowwatch.sv
module tpg_lowwatch #(
    parameter int unsigned T_LOW = 32,
    parameter int unsigned T_REC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_s,
    output logic cl_fault
);

    localparam int unsigned LW = tpg_pkg::cnt_w(T_LOW);
    localparam int unsigned HW = tpg_pkg::cnt_w(T_REC);

    typedef struct packed {
        logic [LW-1:0] low;
        logic [HW-1:0] high;
    } lw_st_t;

    lw_st_t st_d, st_q;
    logic   rec_done;

    always_comb begin
        st_d     = st_q;
        rec_done = txd_s && (st_q.high >= HW'(T_REC - 1));
        cl_fault = !txd_s && (st_q.low >= LW'(T_LOW - 1));
        if (!txd_s) begin
            st_d.high = '0;
            if (st_q.low < LW'(T_LOW - 1)) begin
                st_d.low = st_q.low + 1'b1;
            end
        end else begin
            if (st_q.high < HW'(T_REC)) begin
                st_d.high = st_q.high + 1'b1;
            end
            if (rec_done) begin
                st_d.low = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a qualifying high pulse leaves no low count behind
    assert_low_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> (st_q.low == '0));

endmodule

// File: rtl/tpg_enable.sv
module tpg_enable #(
    parameter int unsigned T_ENA = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_s,
    input  logic bus_s,
    input  logic bc_fault,
    input  logic cl_fault,
    output logic en
);

    import tpg_pkg::*;

    localparam int unsigned ECW = cnt_w(T_ENA);

    typedef struct packed {
        tx_state_e      state;
        logic [ECW-1:0] qual;
    } en_st_t;

    en_st_t st_d, st_q;
    logic   both_high;

    always_comb begin
        st_d      = st_q;
        both_high = txd_s && bus_s;
        if (st_q.state == TX_ON) begin
            if (bc_fault || cl_fault) begin
                st_d.state = TX_OFF;
                st_d.qual  = '0;
            end
        end else if (both_high) begin
            if (st_q.qual >= ECW'(T_ENA - 1)) begin
                st_d.state = TX_ON;
                st_d.qual  = '0;
            end else begin
                st_d.qual = st_q.qual + 1'b1;
            end
        end else begin
            st_d.qual = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: TX_OFF, qual: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign en = (st_q.state == TX_ON);

    // R3: a bit-compare trip while enabled switches the path off
    assert_bc_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bc_fault) |=> !en);

    // R5: a constant-low trip while enabled switches the path off
    assert_cl_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cl_fault) |=> !en);

    // R4: enabling follows a sample with both lines high
    assert_requal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> $past(both_high));

endmodule

// File: rtl/tx_path_guard.sv
module tx_path_guard #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned T_BC        = 4,
    parameter int unsigned T_ENA       = 8,
    parameter int unsigned T_LOW       = 32,
    parameter int unsigned T_REC       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_in,
    input  logic bus_in,
    input  logic ovr_valid_i,
    input  logic ovr_value_i,
    output logic rxd_o,
    output logic tx_en_o,
    output logic status_o,
    output logic status_oe_o
);

    logic [1:0] sync_q;
    logic       txd_s, bus_s;
    logic       bc_fault, cl_fault, en_int;

    tpg_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({txd_in, bus_in}),
        .q     (sync_q)
    );

    assign txd_s = sync_q[1];
    assign bus_s = sync_q[0];

    tpg_bitcmp #(.T_BC(T_BC)) u_bitcmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .txd_s    (txd_s),
        .bus_s    (bus_s),
        .bc_fault (bc_fault)
    );

    tpg_lowwatch #(.T_LOW(T_LOW), .T_REC(T_REC)) u_lowwatch (
        .clk      (clk),
        .rst_n    (rst_n),
        .txd_s    (txd_s),
        .cl_fault (cl_fault)
    );

    tpg_enable #(.T_ENA(T_ENA)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .txd_s    (txd_s),
        .bus_s    (bus_s),
        .bc_fault (bc_fault),
        .cl_fault (cl_fault),
        .en       (en_int)
    );

    always_comb begin
        rxd_o       = bus_s;
        tx_en_o     = ovr_valid_i ? !ovr_value_i : en_int;
        status_oe_o = !ovr_valid_i;
        status_o    = !tx_en_o;
    end

endmodule

// File: tb/sim_tx_path_guard.sv
`timescale 1ns/1ps
module sim_tx_path_guard;

    localparam int T_BC  = 4;
    localparam int T_ENA = 8;
    localparam int T_LOW = 32;
    localparam int T_REC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd_in = 1'b1, bus_in = 1'b1;
    logic ovr_valid_i = 1'b0, ovr_value_i = 1'b0;
    logic rxd_o, tx_en_o, status_o, status_oe_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    string tag = "R2";

    // reference model state
    int m_t1, m_t2, m_b1, m_b2, m_mis, m_low, m_high, m_qual, m_en;

    always #2.5 clk = ~clk;

    tx_path_guard #(.SYNC_STAGES(2), .T_BC(T_BC), .T_ENA(T_ENA),
                    .T_LOW(T_LOW), .T_REC(T_REC)) u0 (
        .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .bus_in(bus_in),
        .ovr_valid_i(ovr_valid_i), .ovr_value_i(ovr_value_i),
        .rxd_o(rxd_o), .tx_en_o(tx_en_o), .status_o(status_o),
        .status_oe_o(status_oe_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        m_t1 = 1; m_t2 = 1; m_b1 = 1; m_b2 = 1;
        m_mis = 0; m_low = 0; m_high = 0; m_qual = 0; m_en = 0;
    endtask

    task automatic model_step();
        bit differ, bcf, clf;
        if (!rst_n) begin
            model_reset();
            return;
        end
        differ = (m_t2 != m_b2);
        bcf = differ && (m_mis >= T_BC);
        clf = (m_t2 == 0) && (m_low >= T_LOW - 1);
        m_mis = differ ? m_mis + 1 : 0;
        if (m_t2 == 0) begin
            m_low++;
            m_high = 0;
        end else begin
            m_high++;
            if (m_high >= T_REC) m_low = 0;
        end
        if (m_en == 1) begin
            if (bcf || clf) begin m_en = 0; m_qual = 0; end
        end else if (m_t2 == 1 && m_b2 == 1) begin
            m_qual++;
            if (m_qual >= T_ENA) begin m_en = 1; m_qual = 0; end
        end else begin
            m_qual = 0;
        end
        m_t2 = m_t1; m_b2 = m_b1;
        m_t1 = int'(txd_in); m_b1 = int'(bus_in);
    endtask

    task automatic compare();
        int exp_en;
        exp_en = ovr_valid_i ? int'(!ovr_value_i) : m_en;
        chk(int'(tx_en_o) == exp_en, tag, int'(tx_en_o), exp_en);
        chk(status_oe_o == !ovr_valid_i, "R9", int'(status_oe_o), int'(!ovr_valid_i));
        if (status_oe_o)
            chk(int'(status_o) == 1 - exp_en, "R9", int'(status_o), 1 - exp_en);
        chk(int'(rxd_o) == m_b2, "R1", int'(rxd_o), m_b2);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model_step();
            compare();
        end
    endtask

    task automatic drv(input bit t, input bit b);
        txd_in = t; bus_in = b;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        model_reset();
        tag = "R2";
        cyc(4);
        chk(tx_en_o == 1'b0, "R2", int'(tx_en_o), 0);
        chk(status_o == 1'b1, "R2", int'(status_o), 1);
        rst_n = 1'b1;
        cyc(3);
        chk(tx_en_o == 1'b0, "R2", int'(tx_en_o), 0);

        tag = "R4";
        drv(1, 1); cyc(12);
        chk(tx_en_o == 1'b1, "R4", int'(tx_en_o), 1);

        tag = "R3";
        for (int i = 0; i < 40; i++) begin
            drv(i % 3 != 0, i % 3 != 0); cyc(1);
        end
        drv(0, 1); cyc(T_BC);
        drv(1, 1); cyc(4);
        chk(tx_en_o == 1'b1, "R3", int'(tx_en_o), 1);
        drv(0, 1); cyc(8);
        chk(tx_en_o == 1'b0, "R3", int'(tx_en_o), 0);

        tag = "R4";
        drv(1, 1); cyc(5);
        drv(1, 0); cyc(1);
        drv(1, 1); cyc(7);
        chk(tx_en_o == 1'b0, "R4", int'(tx_en_o), 0);
        cyc(5);
        chk(tx_en_o == 1'b1, "R4", int'(tx_en_o), 1);

        tag = "R5";
        drv(0, 0); cyc(40);
        chk(tx_en_o == 1'b0, "R5", int'(tx_en_o), 0);
        drv(1, 1); cyc(12);

        tag = "R6";
        drv(0, 0); cyc(20);
        drv(1, 1); cyc(T_REC - 1);
        drv(0, 0); cyc(15);
        chk(tx_en_o == 1'b0, "R6", int'(tx_en_o), 0);
        drv(1, 1); cyc(12);
        drv(0, 0); cyc(20);
        drv(1, 1); cyc(T_REC);
        drv(0, 0); cyc(20);
        chk(tx_en_o == 1'b1, "R6", int'(tx_en_o), 1);
        drv(1, 1); cyc(4);

        tag = "R7";
        ovr_valid_i = 1; ovr_value_i = 0;
        drv(0, 1); cyc(10);
        chk(tx_en_o == 1'b1, "R7", int'(tx_en_o), 1);

        tag = "R8";
        ovr_value_i = 1;
        drv(1, 1); cyc(12);
        chk(tx_en_o == 1'b0, "R8", int'(tx_en_o), 0);

        tag = "R10";
        ovr_valid_i = 0; cyc(4);
        chk(tx_en_o == 1'b1, "R10", int'(tx_en_o), 1);

        for (int i = 0; i < 4000; i++) begin
            bit t;
            t = txd_in;
            if ($urandom_range(0, 99) < 6) t = !t;
            if ($urandom_range(0, 199) < 1) ovr_valid_i = !ovr_valid_i;
            ovr_value_i = ($urandom_range(0, 1) == 1);
            drv(t, ($urandom_range(0, 99) < 4) ? !t : t);
            cyc(1);
        end
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule